// File: doc/BRIEF.md
# Banked register file mapper

This block holds the data memory of a small 8-bit controller and resolves every data access to one physical byte. An access names a 7-bit offset taken from the instruction. Two bank bits in the status register extend it to a 9-bit address that carries the bank. The block then sorts that address into one of five classes. A location can be a core register seen from every bank, a register shared by a pair of banks, the 16-byte window that all banks share, general-purpose RAM private to one bank, or a hole with nothing behind it.

Offset zero is not storage. An access to it goes through the pointer register: the pointer byte is extended by a separate indirect bank bit in the status register, and the access lands on the location that results. Reads are combinational. Writes commit on the clock edge. A write to the status register therefore moves the bank window for the next access only.

Top module: `bank_file_mapper`

## Requirements
- R1: For a nonzero offset the resolved address `eff_addr` equals {status bit 6, status bit 5, addr_off}, so status bits 6:5 = 00/01/10/11 select banks 0/1/2/3.
- R2: The status register keeps only bit 7 (indirect bank), bit 6 and bit 5 (direct bank); bits 4:0 read as zero; a written value is used by the next access after the write edge.
- R3: Offsets 0x70 to 0x7F report region 3 (common) and reach the same 16 bytes from every bank.
- R4: Offset 0x03 (status), 0x04 (pointer), 0x0A (program-counter latch high) and 0x0B (interrupt control) report region 1 (core) and reach one physical register each, whatever the bank.
- R5: Offset 0x06 reports region 2 (mirror); in banks 0 and 2 it is one port data register, in banks 1 and 3 one port direction register.
- R6: General-purpose RAM reports region 4; it covers offsets 0x20 to 0x6F in banks 0 and 1 and offsets 0x10 to 0x6F in banks 2 and 3, with separate storage in each bank.
- R7: Offset 0x00 accesses the location at {status bit 7, pointer}; `eff_addr` shows that address and `hit_region` shows the class of that target.
- R8: When the pointer's low seven bits are zero, an access at offset 0x00 reports region 0, reads zero and its writes change nothing.
- R9: Every other offset reports region 0, reads zero, and writes to it change no stored byte.
- R10: Synchronous reset clears status, pointer, program-counter latch high, interrupt control and port data, and sets the port direction register to 0xFF; RAM is not reset.
- R11: Reads follow the address without a clock; nothing is stored while `wr_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, writes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr_off | input | 7 | Offset field of the direct address |
| wr_en | input | 1 | Write strobe for the current access |
| wr_data | input | 8 | Byte to write |
| rd_data | output | 8 | Byte at the resolved location, zero for holes |
| eff_addr | output | 9 | Resolved bank-qualified address |
| hit_region | output | 3 | Class: 0 none, 1 core, 2 mirror, 3 common, 4 banked RAM |

## Verification
The bench writes a distinct pattern into every offset of all four banks and reads every offset back from every bank. A decoder that folded the common window per bank, put RAM at the same start offset in every bank, or mixed up the port and direction pairing would return another bank's pattern. Every pointer value is swept with both indirect bank settings, which exposes an indirect path that drops the extra bank bit or lets the pointer reach itself. Writes to holes, to the self-referencing pointer, and with the strobe low are each followed by reads of the bytes they could have disturbed, which would show any store that leaked.

// File: rtl/bank_map_pkg.sv
package bank_map_pkg;

    localparam int OFF_W     = 7;
    localparam int BANK_W    = 2;
    localparam int ADDR_W    = BANK_W + OFF_W;
    localparam int DATA_W    = 8;
    localparam int PTR_W     = OFF_W + 1;
    localparam int NUM_BANKS = 1 << BANK_W;
    localparam int BANK_SPAN = 1 << OFF_W;

    // shared window at the top of every bank
    localparam int COMMON_LO    = 'h70;
    localparam int COMMON_BYTES = BANK_SPAN - COMMON_LO;

    // first RAM offset in the lower and upper half of the banks
    localparam int GPR_LO_LOWER = 'h20;
    localparam int GPR_LO_UPPER = 'h10;

    localparam logic [OFF_W-1:0] OFF_INDIRECT = OFF_W'('h00);
    localparam logic [OFF_W-1:0] OFF_STATUS   = OFF_W'('h03);
    localparam logic [OFF_W-1:0] OFF_POINTER  = OFF_W'('h04);
    localparam logic [OFF_W-1:0] OFF_PORTPAIR = OFF_W'('h06);
    localparam logic [OFF_W-1:0] OFF_PCHIGH   = OFF_W'('h0A);
    localparam logic [OFF_W-1:0] OFF_IRQCTL   = OFF_W'('h0B);
    localparam logic [OFF_W-1:0] OFF_COMMON   = OFF_W'(COMMON_LO);

    // status byte layout
    localparam int ST_IND_BANK = 7;
    localparam int ST_BANK_HI  = 6;
    localparam int ST_BANK_LO  = 5;
    localparam int ST_KEPT     = 3;
    localparam logic [DATA_W-1:0] DIR_RESET = '1;

    function automatic int gpr_start(input int bank);
        return (bank < NUM_BANKS / 2) ? GPR_LO_LOWER : GPR_LO_UPPER;
    endfunction

    function automatic int gpr_size(input int bank);
        return COMMON_LO - gpr_start(bank);
    endfunction

    // physical RAM: common window first, then each bank in order
    function automatic int gpr_base(input int bank);
        int acc;
        acc = COMMON_BYTES;
        for (int i = 0; i < bank; i++) acc += gpr_size(i);
        return acc;
    endfunction

    localparam int RAM_DEPTH = gpr_base(NUM_BANKS);
    localparam int RAM_AW    = $clog2(RAM_DEPTH);

    typedef enum logic [2:0] {
        RGN_NONE   = 3'd0,
        RGN_CORE   = 3'd1,
        RGN_MIRROR = 3'd2,
        RGN_COMMON = 3'd3,
        RGN_GPR    = 3'd4
    } region_e;

    typedef enum logic [2:0] {
        CR_NONE,
        CR_STATUS,
        CR_POINTER,
        CR_PCHIGH,
        CR_IRQCTL,
        CR_PORT,
        CR_DIR
    } core_sel_e;

    typedef struct packed {
        region_e           region;
        core_sel_e         core;
        logic [RAM_AW-1:0] ram_idx;
    } decode_t;

endpackage

// File: rtl/bmap_addr_resolve.sv
module bmap_addr_resolve
    import bank_map_pkg::*;
(
    input  logic [OFF_W-1:0]  off,
    input  logic [BANK_W-1:0] bank_sel,
    input  logic              ind_bank,
    input  logic [PTR_W-1:0]  ptr,
    output logic [ADDR_W-1:0] eff_addr
);

    logic [ADDR_W-1:0] direct_addr;
    logic [ADDR_W-1:0] pointer_addr;

    assign direct_addr  = {bank_sel, off};
    assign pointer_addr = {ind_bank, ptr};

    always_comb begin
        if (off == OFF_INDIRECT) eff_addr = pointer_addr;
        else                     eff_addr = direct_addr;
    end

endmodule

// File: rtl/bmap_decode.sv
module bmap_decode
    import bank_map_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output decode_t           dec
);

    logic [OFF_W-1:0]  off;
    logic [BANK_W-1:0] bank;
    logic [NUM_BANKS-1:0] gpr_hit;
    logic [RAM_AW-1:0]    gpr_idx [NUM_BANKS];
    logic [RAM_AW-1:0]    gpr_pick;

    assign off  = addr[OFF_W-1:0];
    assign bank = addr[ADDR_W-1:OFF_W];

    genvar g;
    generate
        for (g = 0; g < NUM_BANKS; g++) begin : g_bank
            localparam int LO   = gpr_start(g);
            localparam int BASE = gpr_base(g);
            assign gpr_hit[g] = (bank == BANK_W'(g))
                              && (int'(off) >= LO)
                              && (int'(off) < COMMON_LO);
            assign gpr_idx[g] = RAM_AW'(BASE + int'(off) - LO);
        end
    endgenerate

    always_comb begin
        gpr_pick = '0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (gpr_hit[i]) gpr_pick = gpr_idx[i];
        end
    end

    always_comb begin
        dec.region  = RGN_NONE;
        dec.core    = CR_NONE;
        dec.ram_idx = '0;
        if (off == OFF_INDIRECT) begin
            // pointer chasing stops at one level
            dec.region = RGN_NONE;
        end else if (off >= OFF_COMMON) begin
            dec.region  = RGN_COMMON;
            dec.ram_idx = RAM_AW'(off - OFF_COMMON);
        end else begin
            case (off)
                OFF_STATUS: begin
                    dec.region = RGN_CORE;
                    dec.core   = CR_STATUS;
                end
                OFF_POINTER: begin
                    dec.region = RGN_CORE;
                    dec.core   = CR_POINTER;
                end
                OFF_PCHIGH: begin
                    dec.region = RGN_CORE;
                    dec.core   = CR_PCHIGH;
                end
                OFF_IRQCTL: begin
                    dec.region = RGN_CORE;
                    dec.core   = CR_IRQCTL;
                end
                OFF_PORTPAIR: begin
                    dec.region = RGN_MIRROR;
                    dec.core   = bank[0] ? CR_DIR : CR_PORT;
                end
                default: begin
                    if (|gpr_hit) begin
                        dec.region  = RGN_GPR;
                        dec.ram_idx = gpr_pick;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/bmap_core_regs.sv
module bmap_core_regs
    import bank_map_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  core_sel_e           sel,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    output logic [ST_KEPT-1:0]  st_bits,
    output logic [PTR_W-1:0]    ptr_q
);

    logic [ST_KEPT-1:0] st_q;
    logic [DATA_W-1:0]  pchigh_q;
    logic [DATA_W-1:0]  irqctl_q;
    logic [DATA_W-1:0]  port_q;
    logic [DATA_W-1:0]  dir_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= '0;
            ptr_q    <= '0;
            pchigh_q <= '0;
            irqctl_q <= '0;
            port_q   <= '0;
            dir_q    <= DIR_RESET;
        end else if (we) begin
            case (sel)
                CR_STATUS:  st_q     <= wdata[ST_IND_BANK:ST_BANK_LO];
                CR_POINTER: ptr_q    <= wdata[PTR_W-1:0];
                CR_PCHIGH:  pchigh_q <= wdata;
                CR_IRQCTL:  irqctl_q <= wdata;
                CR_PORT:    port_q   <= wdata;
                CR_DIR:     dir_q    <= wdata;
                default:    ;
            endcase
        end
    end

    always_comb begin
        case (sel)
            CR_STATUS:  rdata = {st_q, {(DATA_W-ST_KEPT){1'b0}}};
            CR_POINTER: rdata = DATA_W'(ptr_q);
            CR_PCHIGH:  rdata = pchigh_q;
            CR_IRQCTL:  rdata = irqctl_q;
            CR_PORT:    rdata = port_q;
            CR_DIR:     rdata = dir_q;
            default:    rdata = '0;
        endcase
    end

    assign st_bits = st_q;

endmodule

// File: rtl/bmap_ram.sv
module bmap_ram
    import bank_map_pkg::*;
(
    input  logic              clk,
    input  logic              we,
    input  logic [RAM_AW-1:0] idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [RAM_DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[idx] <= wdata;
    end

    assign rdata = mem[idx];

endmodule

// File: rtl/bank_file_mapper.sv
module bank_file_mapper
    import bank_map_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [6:0]        addr_off,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data,
    output logic [8:0]        eff_addr,
    output logic [2:0]        hit_region
);

    logic [ST_KEPT-1:0] st_bits;
    logic [PTR_W-1:0]   ptr_q;
    logic [ADDR_W-1:0]  target;
    decode_t            dec;
    logic               core_we;
    logic               ram_we;
    logic [DATA_W-1:0]  core_rdata;
    logic [DATA_W-1:0]  ram_rdata;

    // st_bits = {indirect bank, bank high, bank low}
    bmap_addr_resolve u_resolve (
        .off      (addr_off),
        .bank_sel (st_bits[BANK_W-1:0]),
        .ind_bank (st_bits[ST_KEPT-1]),
        .ptr      (ptr_q),
        .eff_addr (target)
    );

    bmap_decode u_decode (
        .addr (target),
        .dec  (dec)
    );

    assign core_we = wr_en && ((dec.region == RGN_CORE) || (dec.region == RGN_MIRROR));
    assign ram_we  = wr_en && ((dec.region == RGN_COMMON) || (dec.region == RGN_GPR));

    bmap_core_regs u_core (
        .clk     (clk),
        .rst     (rst),
        .we      (core_we),
        .sel     (dec.core),
        .wdata   (wr_data),
        .rdata   (core_rdata),
        .st_bits (st_bits),
        .ptr_q   (ptr_q)
    );

    bmap_ram u_ram (
        .clk   (clk),
        .we    (ram_we),
        .idx   (dec.ram_idx),
        .wdata (wr_data),
        .rdata (ram_rdata)
    );

    always_comb begin
        case (dec.region)
            RGN_CORE, RGN_MIRROR: rd_data = core_rdata;
            RGN_COMMON, RGN_GPR:  rd_data = ram_rdata;
            default:              rd_data = '0;
        endcase
    end

    assign eff_addr   = target;
    assign hit_region = dec.region;

endmodule

// File: rtl/bank_file_mapper_chk.sv
module bank_file_mapper_chk (
    input logic       clk,
    input logic       rst,
    input logic [6:0] addr_off,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic [8:0] eff_addr,
    input logic [2:0] hit_region,
    input logic [2:0] st_bits,
    input logic [7:0] ptr_q
);

    a_r1_direct_bank: assert property (@(posedge clk) disable iff (rst)
        (addr_off != 7'h00) |-> (eff_addr[8:7] == st_bits[1:0]) && (eff_addr[6:0] == addr_off));

    a_r2_status_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && hit_region == 3'd1 && eff_addr[6:0] == 7'h03)
        |=> (st_bits == $past(wr_data[7:5])));

    a_r3_common_window: assert property (@(posedge clk) disable iff (rst)
        (addr_off >= 7'h70) |-> (hit_region == 3'd3));

    a_r8_self_pointer: assert property (@(posedge clk) disable iff (rst)
        (addr_off == 7'h00 && ptr_q[6:0] == 7'h00) |-> (hit_region == 3'd0 && rd_data == 8'h00));

    a_r9_hole_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (hit_region == 3'd0) |-> (rd_data == 8'h00));

    a_r9_hole_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_en && hit_region == 3'd0) |=> ($stable(st_bits) && $stable(ptr_q)));

    a_r10_reset_clears: assert property (@(posedge clk)
        rst |=> (st_bits == 3'b000 && ptr_q == 8'h00));

endmodule

bind bank_file_mapper bank_file_mapper_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .addr_off   (addr_off),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .eff_addr   (eff_addr),
    .hit_region (hit_region),
    .st_bits    (st_bits),
    .ptr_q      (ptr_q)
);

// File: tb/bank_file_mapper_test.sv
module bank_file_mapper_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] addr_off = 7'h00;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic [8:0] eff_addr;
    logic [2:0] hit_region;

    always #2 clk = ~clk;

    bank_file_mapper uut (
        .clk        (clk),
        .rst        (rst),
        .addr_off   (addr_off),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .eff_addr   (eff_addr),
        .hit_region (hit_region)
    );

    int   n_chk = 0;
    int   n_bad = 0;
    int   cyc   = 0;
    logic [7:0] mdl   [512];
    bit         known [512];

    // bench model of the resolved address (R1, R7)
    function automatic logic [8:0] resolve(input logic [6:0] off);
        if (off != 7'h00) return {mdl[3][6:5], off};
        return {mdl[3][7], mdl[4]};
    endfunction

    // expected class from R3..R6, R8, R9
    function automatic int exp_region(input logic [8:0] a);
        logic [6:0] o;
        int b;
        o = a[6:0];
        b = int'(a[8:7]);
        if (o == 7'h00) return 0;
        if (o >= 7'h70) return 3;
        if (o == 7'h03 || o == 7'h04 || o == 7'h0A || o == 7'h0B) return 1;
        if (o == 7'h06) return 2;
        if (o >= ((b < 2) ? 7'h20 : 7'h10)) return 4;
        return 0;
    endfunction

    // one model slot per physical byte
    function automatic int canon(input logic [8:0] a);
        case (exp_region(a))
            1, 3:    return int'(a[6:0]);
            2:       return a[7] ? 'h86 : 'h06;
            4:       return int'(a);
            default: return -1;
        endcase
    endfunction

    function automatic string rtag(input int r, input logic [6:0] toff);
        case (r)
            1: return "R4";
            2: return "R5";
            3: return "R3";
            4: return "R6";
            default: return (toff == 7'h00) ? "R8" : "R9";
        endcase
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 512; i++) known[i] = 1'b0;
        mdl['h03] = 8'h00; known['h03] = 1'b1;
        mdl['h04] = 8'h00; known['h04] = 1'b1;
        mdl['h0A] = 8'h00; known['h0A] = 1'b1;
        mdl['h0B] = 8'h00; known['h0B] = 1'b1;
        mdl['h06] = 8'h00; known['h06] = 1'b1;
        mdl['h86] = 8'hFF; known['h86] = 1'b1;
    endtask

    task automatic chk(input string tag, input string what,
                       input logic [8:0] act, input logic [8:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic bwrite(input logic [6:0] off, input logic [7:0] d);
        logic [8:0] t;
        int c;
        t = resolve(off);
        c = canon(t);
        @(negedge clk);
        addr_off = off;
        wr_data  = d;
        wr_en    = 1'b1;
        @(negedge clk);
        wr_en    = 1'b0;
        if (c >= 0) begin
            mdl[c]   = (c == 3) ? (d & 8'hE0) : d;
            known[c] = 1'b1;
        end
    endtask

    task automatic bcheck(input logic [6:0] off, input string tag_ovr);
        logic [8:0] t;
        int r;
        int c;
        string tg;
        t = resolve(off);
        r = exp_region(t);
        c = canon(t);
        @(negedge clk);
        addr_off = off;
        wr_en    = 1'b0;
        #1;
        tg = (tag_ovr != "") ? tag_ovr : rtag(r, t[6:0]);
        chk((off == 7'h00) ? "R7" : "R1", "eff_addr", eff_addr, t);
        chk(tg, "region", {6'd0, hit_region}, 9'(r));
        if (r == 0)
            chk(tg, "data", {1'b0, rd_data}, 9'h000);
        else if (c >= 0 && known[c])
            chk(tg, "data", {1'b0, rd_data}, {1'b0, mdl[c]});
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
            finish_run();
        end
    end

    task automatic reset_checks();
        // R10: core registers after reset, bank 0 then bank 1
        bcheck(7'h03, "R10");
        bcheck(7'h04, "R10");
        bcheck(7'h0A, "R10");
        bcheck(7'h0B, "R10");
        bcheck(7'h06, "R10");
        bwrite(7'h03, 8'h20);
        bcheck(7'h06, "R10");
        bwrite(7'h03, 8'h00);
    endtask

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        reset_checks();

        // R2: unkept status bits read zero, kept ones survive
        bwrite(7'h03, 8'hFF);
        bcheck(7'h03, "R2");
        bwrite(7'h03, 8'h00);
        bcheck(7'h03, "R2");

        // R11: strobe low stores nothing
        bwrite(7'h25, 8'h11);
        @(negedge clk);
        addr_off = 7'h25;
        wr_data  = 8'hEE;
        wr_en    = 1'b0;
        @(negedge clk);
        bcheck(7'h25, "R11");
        bwrite(7'h03, 8'h40);
        @(negedge clk);
        addr_off = 7'h03;
        wr_data  = 8'h00;
        wr_en    = 1'b0;
        @(negedge clk);
        bcheck(7'h03, "R11");

        // fill every offset of every bank; holes take writes too (R9)
        for (int b = 0; b < 4; b++) begin
            bwrite(7'h03, 8'(b << 5));
            for (int o = 1; o < 128; o++) begin
                if (o != 3) bwrite(7'(o), 8'((b * 53 + o * 7 + 3) & 'hFF));
            end
        end

        // read every offset from every bank (R1, R3..R6, R9)
        for (int b = 0; b < 4; b++) begin
            bwrite(7'h03, 8'(b << 5));
            for (int o = 1; o < 128; o++) bcheck(7'(o), "");
        end

        // pointer sweep with both indirect bank values (R7, R8)
        for (int ib = 0; ib < 2; ib++) begin
            bwrite(7'h03, 8'(ib << 7));
            for (int p = 0; p < 256; p++) begin
                bwrite(7'h04, 8'(p));
                bcheck(7'h00, "");
            end
        end

        // writes through the pointer land on the target (R7)
        bwrite(7'h03, 8'h80);
        bwrite(7'h04, 8'h20);
        bwrite(7'h00, 8'h5A);
        bwrite(7'h03, 8'h40);
        bcheck(7'h20, "R7");
        bwrite(7'h03, 8'h80);
        bwrite(7'h04, 8'h86);
        bwrite(7'h00, 8'hC3);
        bwrite(7'h03, 8'h20);
        bcheck(7'h06, "R7");
        bwrite(7'h04, 8'h72);
        bwrite(7'h00, 8'h9D);
        bwrite(7'h03, 8'h60);
        bcheck(7'h72, "R7");

        // self reference: writes change nothing (R8)
        for (int ib = 0; ib < 2; ib++) begin
            for (int hi = 0; hi < 2; hi++) begin
                bwrite(7'h03, 8'((ib << 7) | 8'h20));
                bwrite(7'h04, 8'(hi << 7));
                bwrite(7'h00, 8'h77);
                bcheck(7'h00, "R8");
                bcheck(7'h03, "R8");
                bcheck(7'h04, "R8");
                bcheck(7'h06, "R8");
                bcheck(7'h70, "R8");
            end
        end

        // R9: the holes written earlier left all real bytes intact
        for (int b = 0; b < 4; b++) begin
            bwrite(7'h03, 8'(b << 5));
            for (int o = 1; o < 32; o++) bcheck(7'(o), "");
        end

        // R10: reset again after all registers hold data
        bwrite(7'h0A, 8'h3C);
        bwrite(7'h0B, 8'hA5);
        bwrite(7'h04, 8'h99);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        reset_checks();

        finish_run();
    end

endmodule